// File: doc/BRIEF.md
# Self-Clocked Converter Serial Output Sequencer

This block is the output side of a serial analog-to-digital converter that has no clock of its own: every step of a conversion frame is paced by the falling edges of the serial clock supplied by the host. A frame opens when chip select goes low. At that moment the block captures a parallel sample word. The data pin stays released for a sampling phase of five falling clock edges. It is then driven low for one period as a null bit. Next the word is sent most significant bit first, and then sent back least significant bit first. After the top bit has gone out a second time, the pin is released again and stays released until chip select has gone high and low once more.

The block runs on a local system clock. Chip select and the serial clock pass through synchronizers, and the block detects their edges. This makes it suitable as a synthesizable converter model when a serial host controller is being tested. The analog sampling and the conversion arithmetic are outside this block; the value to send arrives on a parallel input.

Top module: `adc_sout_seq`

## Requirements
- R1: While reset is applied and after it is released, `dout_oe_o` is 0 and `dout_o` is 0 until a frame is opened.
- R2: The word on `sample_i` is captured when the falling edge of `cs_ni` is detected. Changes on `sample_i` later in the frame have no effect on the bits sent.
- R3: From the opening of the frame through the fifth falling edge of `sclk_i` not yet reached, `dout_oe_o` is 0 and `dout_o` is 0.
- R4: After the fifth falling edge of `sclk_i`, `dout_oe_o` is 1 and `dout_o` is 0 until the sixth falling edge.
- R5: After falling edges 6 through 21, `dout_o` carries sample bits 15 down to 0, one bit per period, with `dout_oe_o` at 1.
- R6: After falling edges 22 through 36, `dout_o` carries sample bits 1 up to 15, with `dout_oe_o` at 1. Bit 0 is not sent a second time.
- R7: From the 37th falling edge on, `dout_oe_o` is 0 and `dout_o` is 0. Further falling edges change nothing while `cs_ni` stays low.
- R8: When `cs_ni` is high, `dout_oe_o` drops to 0 within SYNC_STAGES+1 system clocks at any point of a frame. The frame is abandoned, and the next falling edge of `cs_ni` starts again from the sampling phase.
- R9: Rising edges of `sclk_i` have no effect. The outputs change only after a detected falling edge of `sclk_i` or an edge of `cs_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select from host, active low, asynchronous |
| sclk_i | input | 1 | Serial clock from host, asynchronous |
| sample_i | input | DATA_W | Parallel sample word to be sent |
| dout_o | output | 1 | Serial data value, 0 when released |
| dout_oe_o | output | 1 | Drive enable for the data pin, 1 when driven |

## Verification
A wrong phase or bit index shows up at the pins within one serial clock period. The enable can rise one edge too early or too late, the null bit can be missing, or the word can come out shifted by one position. The mistake shows most clearly at the seam where the word turns around, since bit 0 must appear only once. A sequencer that fails to stay in its finished state shows up as the pin being driven again on the 38th and later edges. A capture register that does not hold its value shows up as the complement of the sample, because the bench inverts `sample_i` right after opening the frame.

// File: rtl/adc_sout_pkg.sv
package adc_sout_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SAMPLE,
    PH_NULL,
    PH_MSB,
    PH_LSB,
    PH_DONE
  } phase_e;

  function automatic logic phase_drives(phase_e ph);
    return (ph == PH_NULL) || (ph == PH_MSB) || (ph == PH_LSB);
  endfunction

endpackage

// File: rtl/adc_sout_sync.sv
module adc_sout_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic lvl_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= RST_VAL;
        else         chain_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= RST_VAL;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/adc_sout_frame_ctrl.sv
module adc_sout_frame_ctrl
  import adc_sout_pkg::*;
#(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned SAMPLE_EDGES = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cs_lvl_i,
  input  logic                      cs_fall_i,
  input  logic                      sclk_fall_i,
  output phase_e                    phase_o,
  output logic [$clog2(DATA_W)-1:0] idx_o
);

  localparam int unsigned CNT_MAX = (DATA_W > SAMPLE_EDGES) ? DATA_W : SAMPLE_EDGES;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX);
  localparam int unsigned IDX_W   = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] SMP_LAST  = CNT_W'(SAMPLE_EDGES - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(DATA_W - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] cnt_idx;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (cs_fall_i) begin
      phase_d = PH_SAMPLE;
      cnt_d   = '0;
    end else if (cs_lvl_i) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else if (sclk_fall_i) begin
      unique case (phase_q)
        PH_SAMPLE: begin
          if (cnt_q == SMP_LAST) begin
            phase_d = PH_NULL;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_NULL: begin
          phase_d = PH_MSB;
          cnt_d   = '0;
        end
        PH_MSB: begin
          // bit 0 is shared by both orders: reverse pass opens at bit 1
          if (cnt_q == WORD_LAST) begin
            phase_d = PH_LSB;
            cnt_d   = CNT_W'(1);
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_LSB: begin
          if (cnt_q == WORD_LAST) begin
            phase_d = PH_DONE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cnt_idx = cnt_q[IDX_W-1:0];
  assign phase_o = phase_q;
  assign idx_o   = (phase_q == PH_MSB) ? (IDX_W'(DATA_W - 1) - cnt_idx) : cnt_idx;

endmodule

// File: rtl/adc_sout_bit_mux.sv
module adc_sout_bit_mux
  import adc_sout_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [DATA_W-1:0]         sample_i,
  input  phase_e                    phase_i,
  input  logic [$clog2(DATA_W)-1:0] idx_i,
  output logic                      dout_o,
  output logic                      oe_o
);

  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= sample_i;
  end

  always_comb begin
    oe_o   = phase_drives(phase_i);
    dout_o = 1'b0;
    if (phase_i == PH_MSB || phase_i == PH_LSB) dout_o = word_q[idx_i];
  end

endmodule

// File: rtl/adc_sout_seq.sv
module adc_sout_seq
  import adc_sout_pkg::*;
#(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned SAMPLE_EDGES = 5,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              dout_o,
  output logic              dout_oe_o
);

  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic             cs_lvl, cs_fall;
  logic             sclk_lvl, sclk_fall;
  phase_e           phase;
  logic [IDX_W-1:0] idx;

  // reset low: cs must be seen high before a frame can open
  adc_sout_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cs_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(cs_ni),
    .lvl_o  (cs_lvl),
    .fall_o (cs_fall)
  );

  adc_sout_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sclk_i),
    .lvl_o  (sclk_lvl),
    .fall_o (sclk_fall)
  );

  adc_sout_frame_ctrl #(.DATA_W(DATA_W), .SAMPLE_EDGES(SAMPLE_EDGES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_lvl_i   (cs_lvl),
    .cs_fall_i  (cs_fall),
    .sclk_fall_i(sclk_fall),
    .phase_o    (phase),
    .idx_o      (idx)
  );

  adc_sout_bit_mux #(.DATA_W(DATA_W)) u_mux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cs_fall),
    .sample_i(sample_i),
    .phase_i (phase),
    .idx_i   (idx),
    .dout_o  (dout_o),
    .oe_o    (dout_oe_o)
  );

endmodule

// File: rtl/adc_sout_seq_chk.sv
module adc_sout_seq_chk #(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned SAMPLE_EDGES = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_lvl_i,
  input logic sclk_lvl_i,
  input logic dout_i,
  input logic oe_i
);

  localparam int unsigned TOTAL = SAMPLE_EDGES + 2 * DATA_W;
  localparam int unsigned FC_W  = $clog2(TOTAL + 1);

  logic            cs_q, sclk_q, active_q;
  logic [FC_W-1:0] fcnt_q;
  logic            cs_f, sclk_f;

  assign cs_f   = cs_q & ~cs_lvl_i;
  assign sclk_f = sclk_q & ~sclk_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q     <= 1'b0;
      sclk_q   <= 1'b0;
      active_q <= 1'b0;
      fcnt_q   <= '0;
    end else begin
      cs_q   <= cs_lvl_i;
      sclk_q <= sclk_lvl_i;
      if (cs_f) begin
        active_q <= 1'b1;
        fcnt_q   <= '0;
      end else if (cs_lvl_i) begin
        active_q <= 1'b0;
        fcnt_q   <= '0;
      end else if (sclk_f && active_q && fcnt_q != FC_W'(TOTAL)) begin
        fcnt_q <= fcnt_q + 1'b1;
      end
    end
  end

  p_idle_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> (!oe_i && !dout_i));

  p_sample_hiz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && fcnt_q < FC_W'(SAMPLE_EDGES)) |-> (!oe_i && !dout_i));

  p_null_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && fcnt_q == FC_W'(SAMPLE_EDGES)) |-> (oe_i && !dout_i));

  p_word_driven_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && fcnt_q > FC_W'(SAMPLE_EDGES) && fcnt_q < FC_W'(TOTAL)) |-> oe_i);

  p_done_hiz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcnt_q == FC_W'(TOTAL)) |-> (!oe_i && !dout_i));

  p_cs_high_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_lvl_i |=> !oe_i);

  p_quiet_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclk_f && !cs_f && !cs_lvl_i) |=> $stable({dout_i, oe_i}));

endmodule

bind adc_sout_seq adc_sout_seq_chk #(
  .DATA_W      (DATA_W),
  .SAMPLE_EDGES(SAMPLE_EDGES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_lvl_i  (cs_lvl),
  .sclk_lvl_i(sclk_lvl),
  .dout_i    (dout_o),
  .oe_i      (dout_oe_o)
);

// File: tb/adc_sout_seq_test.sv
`timescale 1ns/1ps
module adc_sout_seq_test;

  localparam int DW = 16;

  typedef struct {
    logic  oe;
    logic  dout;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          sclk = 1'b1;
  logic [DW-1:0] sample = '0;
  logic          dout, oe;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   finished = 0;
  exp_t q[$];
  event smp_ev;

  always #2.5 clk = ~clk;

  adc_sout_seq uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .cs_ni    (cs_n),
    .sclk_i   (sclk),
    .sample_i (sample),
    .dout_o   (dout),
    .dout_oe_o(oe)
  );

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_out(input logic e_oe, input logic e_dout, input string tag);
    exp_t e;
    e.oe = e_oe; e.dout = e_dout; e.tag = tag;
    q.push_back(e);
    -> smp_ev;
    @(negedge clk);
  endtask

  // monitor: pops one expected item per sample point
  initial begin
    forever begin
      exp_t e;
      @(smp_ev);
      e = q.pop_front();
      n_vec++;
      if (oe !== e.oe || dout !== e.dout) begin
        n_bad++;
        $display("FAIL %s: actual oe=%b dout=%b expected oe=%b dout=%b",
                 e.tag, oe, dout, e.oe, e.dout);
      end
    end
  end

  function automatic logic [1:0] model(input int k, input logic [DW-1:0] w);
    if (k < 5)   return 2'b00;
    if (k == 5)  return 2'b10;
    if (k <= 21) return {1'b1, w[21-k]};
    if (k <= 36) return {1'b1, w[k-21]};
    return 2'b00;
  endfunction

  function automatic string tag_of(input int k);
    if (k < 5)   return "R3";
    if (k == 5)  return "R4";
    if (k == 6)  return "R2";
    if (k <= 21) return "R5";
    if (k <= 36) return "R6";
    return "R7";
  endfunction

  task automatic run_frame(input logic [DW-1:0] w, input int nfalls);
    logic [1:0] ex;
    sample = w;
    wait_clk(8);
    cs_n = 1'b0;
    wait_clk(8);
    expect_out(1'b0, 1'b0, "R3");
    sample = ~w; // R2: post-capture change must not leak into the word
    for (int k = 1; k <= nfalls; k++) begin
      ex = model(k, w);
      sclk = 1'b0;
      wait_clk(6);
      expect_out(ex[1], ex[0], tag_of(k));
      wait_clk(1);
      sclk = 1'b1;
      wait_clk(6);
      expect_out(ex[1], ex[0], "R9"); // rising edge leaves outputs alone
      wait_clk(1);
    end
    cs_n = 1'b1;
    wait_clk(3); // SYNC_STAGES+1
    expect_out(1'b0, 1'b0, "R8");
    wait_clk(4);
  endtask

  initial begin
    wait_clk(3);
    expect_out(1'b0, 1'b0, "R1");
    rst_n = 1'b1;
    wait_clk(4);
    expect_out(1'b0, 1'b0, "R1");

    run_frame(16'hA5C3, 40);  // full frame plus extra edges (R7)
    run_frame(16'h0001, 37);
    run_frame(16'h8000, 12);  // abandoned mid-word (R8)
    run_frame(16'h8000, 37);  // restarts from sampling phase
    run_frame(16'hFFFF, 3);   // abandoned in sampling phase
    run_frame(16'h3C96, 38);

    wait_clk(4);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1: watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule